// File: doc/BRIEF.md
# Load/Store Address and Lane Unit

This block sits between a core's register read stage and its data memory port. For every access it forms the effective byte address from a base register value and an offset. The offset is either an immediate or a second register shifted left by a small amount, and it is added or subtracted. The block also produces the base-register update for the pre-indexed and post-indexed modes, steers store data onto the correct byte lanes with matching byte enables, and extracts and zero-extends byte and halfword load results from the returned memory word.

Byte ordering inside a 32-bit bus word is either little-endian or big-endian. The order is picked from a configuration pin that is sampled only while reset is asserted and then held. A request is accepted on any cycle with `req_valid` high. The bus-side outputs are registered one cycle later. The memory word for a load is presented during that output cycle, and the extended load value appears registered one cycle after that. Accesses whose address is not aligned to their size are flagged, and no bytes are enabled for them.

Top module: `ls_addr_lane`

## Requirements
- R1: The offset equals `req_reg << req_shamt` when `req_use_reg` is 1 and `req_imm` otherwise. With `req_sub` 1 it is subtracted from the base, otherwise added, modulo 2^32.
- R2: Mode 0 (offset), and also mode 3, drives base±offset onto `out_addr` and keeps `out_wb_en` low.
- R3: Mode 1 (pre-index) drives base±offset onto `out_addr`, raises `out_wb_en` and puts the same sum on `out_wb_data`.
- R4: Mode 2 (post-index) drives the unmodified base onto `out_addr`, raises `out_wb_en` and puts base±offset on `out_wb_data`.
- R5: Byte order is taken from `cfg_big_endian` while `rst` is high (1 = big-endian). Changes of that pin outside reset have no effect. Byte address b maps to lane b (bits 8b+7:8b) when little-endian and to lane 3-b when big-endian.
- R6: A byte access (size 0) enables only the single lane of its address, and `out_wdata` holds the store byte replicated four times.
- R7: A halfword access (size 1) enables the two lanes holding its bytes: 4'b0011 for address offset 0 and 4'b1100 for offset 2 when little-endian, swapped when big-endian. `out_wdata` holds the store halfword replicated twice.
- R8: A word access (size 2, and also size 3) enables all four lanes and passes the store word unchanged.
- R9: A byte or halfword load returns the selected lanes of `mem_rdata` zero-extended to 32 bits on `ld_data`, using the same lane mapping. A word load returns `mem_rdata` unchanged.
- R10: A halfword access with an odd address, or a word access with address bits 1:0 not zero, raises `out_err`, drives `out_be` to zero, keeps `out_wb_en` low and produces no `ld_valid`.
- R11: Bus outputs and `out_valid` appear on the clock edge after the request. For a valid aligned load, `ld_valid` and `ld_data` appear on the next edge, formed from `mem_rdata` as sampled in the `out_valid` cycle. All outputs are zero while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_big_endian | input | 1 | Byte order select, sampled only during reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_mode | input | 2 | 0/3 offset, 1 pre-index, 2 post-index |
| req_base | input | 32 | Base register value |
| req_imm | input | 32 | Immediate offset |
| req_reg | input | 32 | Register offset |
| req_use_reg | input | 1 | Select register offset |
| req_shamt | input | 5 | Left shift of the register offset |
| req_sub | input | 1 | Subtract the offset |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_rdata | input | 32 | Memory read word for the pending load |
| out_valid | output | 1 | Bus outputs valid |
| out_store | output | 1 | Access is a store |
| out_addr | output | 32 | Byte address of the access |
| out_be | output | 4 | Byte lane enables |
| out_wdata | output | 32 | Lane-replicated store word |
| out_err | output | 1 | Misaligned access |
| out_wb_en | output | 1 | Write back base register |
| out_wb_data | output | 32 | New base register value |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Zero-extended load result |

## Verification
Address generation for a new request and lane extraction for the preceding load share a cycle. The memory word of load A is presented in the very cycle in which request B is driven. The next edge must then show A's extended result on `ld_data` alongside B's address, enables and writeback, with neither disturbing the other. The bench provokes this with back-to-back load/store pairs in both byte orders and judges both sets of outputs against its own arithmetic model in that one sample.

// File: rtl/ls_pkg.sv
package ls_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    AM_OFFSET  = 2'd0,
    AM_PRE     = 2'd1,
    AM_POST    = 2'd2,
    AM_OFFSET3 = 2'd3
  } addr_mode_e;
endpackage

// File: rtl/ls_agen.sv
module ls_agen #(
  parameter int AW   = 32,
  parameter int SH_W = 5
) (
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   imm,
  input  logic [AW-1:0]   regv,
  input  logic            use_reg,
  input  logic [SH_W-1:0] shamt,
  input  logic            sub,
  input  logic [1:0]      mode,
  output logic [AW-1:0]   acc_addr,
  output logic            indexed,
  output logic [AW-1:0]   new_base
);
  import ls_pkg::*;

  logic [AW-1:0] offset;
  logic [AW-1:0] sum;

  always_comb begin
    offset = use_reg ? (regv << shamt) : imm;
    sum    = sub ? (base - offset) : (base + offset);
    unique case (addr_mode_e'(mode))
      AM_PRE:  begin acc_addr = sum;  indexed = 1'b1; end
      AM_POST: begin acc_addr = base; indexed = 1'b1; end
      default: begin acc_addr = sum;  indexed = 1'b0; end
    endcase
    new_base = sum;
  end
endmodule

// File: rtl/ls_store_lane.sv
module ls_store_lane #(
  parameter int DW = 32
) (
  input  logic [1:0]      size,
  input  logic [1:0]      lo,
  input  logic            big,
  input  logic [DW-1:0]   wdata,
  output logic [DW/8-1:0] be,
  output logic [DW-1:0]   lane_data,
  output logic            misalign
);
  import ls_pkg::*;
  localparam int NB = DW / 8;
  localparam int NH = DW / 16;

  logic [DW-1:0] byte_rep;
  logic [DW-1:0] half_rep;

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_brep
      assign byte_rep[g*8 +: 8] = wdata[7:0];
    end
    for (g = 0; g < NH; g++) begin : g_hrep
      assign half_rep[g*16 +: 16] = wdata[15:0];
    end
  endgenerate

  always_comb begin
    be        = '0;
    lane_data = wdata;
    misalign  = 1'b0;
    unique case (acc_size_e'(size))
      SZ_BYTE: begin
        lane_data = byte_rep;
        unique case ({big, lo})
          3'b000, 3'b111: be = 4'b0001;
          3'b001, 3'b110: be = 4'b0010;
          3'b010, 3'b101: be = 4'b0100;
          default:        be = 4'b1000;
        endcase
      end
      SZ_HALF: begin
        lane_data = half_rep;
        misalign  = lo[0];
        if (!lo[0]) be = (lo[1] ^ big) ? 4'b1100 : 4'b0011;
      end
      default: begin
        misalign = |lo;
        if (lo == 2'b00) be = '1;
      end
    endcase
  end
endmodule

// File: rtl/ls_load_lane.sv
module ls_load_lane #(
  parameter int DW = 32
) (
  input  logic [1:0]    size,
  input  logic [1:0]    lo,
  input  logic          big,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] value
);
  import ls_pkg::*;

  logic [1:0] bsel;
  logic       hsel;
  logic [7:0]  bval;
  logic [15:0] hval;

  always_comb begin
    bsel = big ? ~lo : lo;
    hsel = lo[1] ^ big;
    unique case (bsel)
      2'd0:    bval = rdata[7:0];
      2'd1:    bval = rdata[15:8];
      2'd2:    bval = rdata[23:16];
      default: bval = rdata[31:24];
    endcase
    hval = hsel ? rdata[31:16] : rdata[15:0];
    unique case (acc_size_e'(size))
      SZ_BYTE: value = {{(DW-8){1'b0}}, bval};
      SZ_HALF: value = {{(DW-16){1'b0}}, hval};
      default: value = rdata;
    endcase
  end
endmodule

// File: rtl/ls_addr_lane.sv
module ls_addr_lane #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int SH_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_big_endian,
  input  logic            req_valid,
  input  logic            req_store,
  input  logic [1:0]      req_size,
  input  logic [1:0]      req_mode,
  input  logic [AW-1:0]   req_base,
  input  logic [AW-1:0]   req_imm,
  input  logic [AW-1:0]   req_reg,
  input  logic            req_use_reg,
  input  logic [SH_W-1:0] req_shamt,
  input  logic            req_sub,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            out_valid,
  output logic            out_store,
  output logic [AW-1:0]   out_addr,
  output logic [DW/8-1:0] out_be,
  output logic [DW-1:0]   out_wdata,
  output logic            out_err,
  output logic            out_wb_en,
  output logic [AW-1:0]   out_wb_data,
  output logic            ld_valid,
  output logic [DW-1:0]   ld_data
);
  localparam int NB = DW / 8;

  logic            big_q;
  logic [AW-1:0]   acc_addr;
  logic            indexed;
  logic [AW-1:0]   new_base;
  logic [NB-1:0]   be_c;
  logic [DW-1:0]   lane_c;
  logic            mis_c;
  logic [1:0]      size_q;
  logic [DW-1:0]   ld_c;

  always_ff @(posedge clk) begin
    if (rst) big_q <= cfg_big_endian;
  end

  ls_agen #(.AW(AW), .SH_W(SH_W)) u_agen (
    .base(req_base), .imm(req_imm), .regv(req_reg), .use_reg(req_use_reg),
    .shamt(req_shamt), .sub(req_sub), .mode(req_mode),
    .acc_addr(acc_addr), .indexed(indexed), .new_base(new_base)
  );

  ls_store_lane #(.DW(DW)) u_st (
    .size(req_size), .lo(acc_addr[1:0]), .big(big_q), .wdata(req_wdata),
    .be(be_c), .lane_data(lane_c), .misalign(mis_c)
  );

  ls_load_lane #(.DW(DW)) u_ld (
    .size(size_q), .lo(out_addr[1:0]), .big(big_q), .rdata(mem_rdata),
    .value(ld_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_store   <= 1'b0;
      out_addr    <= '0;
      out_be      <= '0;
      out_wdata   <= '0;
      out_err     <= 1'b0;
      out_wb_en   <= 1'b0;
      out_wb_data <= '0;
      size_q      <= '0;
      ld_valid    <= 1'b0;
      ld_data     <= '0;
    end else begin
      out_valid   <= req_valid;
      out_store   <= req_valid & req_store;
      out_addr    <= req_valid ? acc_addr : '0;
      out_be      <= (req_valid & ~mis_c) ? be_c : '0;
      out_wdata   <= req_valid ? lane_c : '0;
      out_err     <= req_valid & mis_c;
      out_wb_en   <= req_valid & indexed & ~mis_c;
      out_wb_data <= req_valid ? new_base : '0;
      size_q      <= req_size;
      ld_valid    <= out_valid & ~out_store & ~out_err;
      if (out_valid & ~out_store & ~out_err) ld_data <= ld_c;
    end
  end
endmodule

// File: rtl/ls_addr_lane_chk.sv
module ls_addr_lane_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_big_endian,
  input logic            big_q,
  input logic            req_valid,
  input logic [1:0]      req_size,
  input logic [1:0]      req_mode,
  input logic [AW-1:0]   req_base,
  input logic            out_valid,
  input logic            out_store,
  input logic [AW-1:0]   out_addr,
  input logic [DW/8-1:0] out_be,
  input logic            out_err,
  input logic            out_wb_en,
  input logic            ld_valid
);
  p_err_no_lanes_r10: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_be == '0 && !out_wb_en));

  p_wb_needs_access_r3: assert property (@(posedge clk) disable iff (rst)
    out_wb_en |-> (out_valid && !out_err));

  p_ld_follows_r11: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(out_valid && !out_store && !out_err));

  p_order_held_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(big_q));

  p_post_uses_base_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(req_valid) && $past(req_mode) == 2'd2) |-> out_addr == $past(req_base));

  p_byte_one_lane_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(req_valid) && $past(req_size) == 2'd0) |-> $countones(out_be) == 1);

  p_half_two_lanes_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(req_valid) && $past(req_size) == 2'd1 && !out_err) |-> $countones(out_be) == 2);

  p_offset_no_wb_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(req_valid) && ($past(req_mode) == 2'd0 || $past(req_mode) == 2'd3)) |-> !out_wb_en);
endmodule

bind ls_addr_lane ls_addr_lane_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cfg_big_endian(cfg_big_endian), .big_q(big_q),
  .req_valid(req_valid), .req_size(req_size), .req_mode(req_mode),
  .req_base(req_base), .out_valid(out_valid), .out_store(out_store),
  .out_addr(out_addr), .out_be(out_be), .out_err(out_err),
  .out_wb_en(out_wb_en), .ld_valid(ld_valid)
);

// File: tb/test_ls_addr_lane.sv
`timescale 1ns/1ps
module test_ls_addr_lane;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_big_endian = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_use_reg = 1'b0, req_sub = 1'b0;
  logic [1:0]  req_size = '0, req_mode = '0;
  logic [31:0] req_base = '0, req_imm = '0, req_reg = '0, req_wdata = '0, mem_rdata = '0;
  logic [4:0]  req_shamt = '0;
  logic        out_valid, out_store, out_err, out_wb_en, ld_valid;
  logic [31:0] out_addr, out_wdata, out_wb_data, ld_data;
  logic [3:0]  out_be;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  ls_addr_lane i_ls_addr_lane (
    .clk(clk), .rst(rst), .cfg_big_endian(cfg_big_endian),
    .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
    .req_mode(req_mode), .req_base(req_base), .req_imm(req_imm),
    .req_reg(req_reg), .req_use_reg(req_use_reg), .req_shamt(req_shamt),
    .req_sub(req_sub), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_store(out_store), .out_addr(out_addr),
    .out_be(out_be), .out_wdata(out_wdata), .out_err(out_err),
    .out_wb_en(out_wb_en), .out_wb_data(out_wb_data),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected-value model
  logic [31:0] e_addr, e_wb, e_wdata;
  logic [3:0]  e_be;
  logic        e_err, e_wben;
  logic        big_model;

  task automatic model(input logic st, input logic [1:0] sz, input logic [1:0] md,
                       input logic [31:0] b, input logic [31:0] im, input logic [31:0] rg,
                       input logic ur, input logic [4:0] sh, input logic sb, input logic [31:0] wd);
    logic [31:0] off, sum;
    logic [1:0] lo;
    int lane;
    off  = ur ? (rg << sh) : im;
    sum  = sb ? b - off : b + off;
    e_addr = (md == 2'd2) ? b : sum;
    e_wb = sum;
    lo = e_addr[1:0];
    e_err = (sz == 2'd1 && lo[0]) || (sz >= 2'd2 && lo != 2'd0);
    e_wben = (md == 2'd1 || md == 2'd2) && !e_err;
    if (e_err) e_be = 4'd0;
    else if (sz == 2'd0) begin
      lane = big_model ? 3 - int'(lo) : int'(lo);
      e_be = 4'd1 << lane;
    end else if (sz == 2'd1) begin
      lane = big_model ? 2 - int'(lo) : int'(lo);
      e_be = 4'b0011 << lane;
    end else e_be = 4'hF;
    if (sz == 2'd0) e_wdata = wd[7:0] * 32'h0101_0101;
    else if (sz == 2'd1) e_wdata = wd[15:0] * 32'h0001_0001;
    else e_wdata = wd;
  endtask

  function automatic logic [31:0] ld_model(input logic [1:0] sz, input logic [1:0] lo, input logic [31:0] rd);
    int lane;
    if (sz == 2'd0) begin
      lane = big_model ? 3 - int'(lo) : int'(lo);
      return (rd >> (8 * lane)) & 32'hFF;
    end else if (sz == 2'd1) begin
      lane = big_model ? 2 - int'(lo) : int'(lo);
      return (rd >> (8 * lane)) & 32'hFFFF;
    end
    return rd;
  endfunction

  task automatic do_reset(input logic big);
    @(negedge clk);
    rst = 1'b1; cfg_big_endian = big; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    big_model = big;
    cfg_big_endian = ~big;  // R5: ignored outside reset
  endtask

  task automatic drive(input logic st, input logic [1:0] sz, input logic [1:0] md,
                       input logic [31:0] b, input logic [31:0] im, input logic [31:0] rg,
                       input logic ur, input logic [4:0] sh, input logic sb, input logic [31:0] wd);
    req_valid = 1'b1; req_store = st; req_size = sz; req_mode = md; req_base = b;
    req_imm = im; req_reg = rg; req_use_reg = ur; req_shamt = sh; req_sub = sb; req_wdata = wd;
    model(st, sz, md, b, im, rg, ur, sh, sb, wd);
  endtask

  task automatic check_bus(input logic st);
    chk(out_valid === 1'b1, "R11 out_valid", {31'd0, out_valid}, 32'd1);
    chk(out_addr === e_addr, "R1 R2 R3 R4 address", out_addr, e_addr);
    chk(out_err === e_err, "R10 misalign flag", {31'd0, out_err}, {31'd0, e_err});
    chk(out_be === e_be, "R5 R6 R7 R8 byte enables", {28'd0, out_be}, {28'd0, e_be});
    chk(out_wb_en === e_wben, "R2 R3 R4 writeback enable", {31'd0, out_wb_en}, {31'd0, e_wben});
    if (e_wben) chk(out_wb_data === e_wb, "R3 R4 writeback value", out_wb_data, e_wb);
    if (st && !e_err) chk(out_wdata === e_wdata, "R6 R7 R8 store lanes", out_wdata, e_wdata);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] b, im, rg, wd, rd, exp_ld;
    logic [1:0]  sz_a, lo_a;
    logic        err_a;
    big_model = 1'b0;
    repeat (2) @(negedge clk);
    // reset state (R11)
    chk(out_valid === 1'b0 && ld_valid === 1'b0 && out_be === 4'd0 && out_addr === 32'd0,
        "R11 reset state", {out_valid, ld_valid, out_be, 26'd0}, 32'd0);

    for (int bg = 0; bg < 2; bg++) begin
      do_reset(bg[0]);
      for (int i = 0; i < 512; i++) begin
        seed = nxt(seed); b  = {seed[31:2], i[8:7]};
        seed = nxt(seed); im = {seed[31:2], 2'b00};
        seed = nxt(seed); rg = seed;
        seed = nxt(seed); wd = seed;
        drive(i[6], i[3:2], i[1:0], b, im, rg, i[5], {3'd0, seed[17:16]}, i[4], wd);
        @(negedge clk);
        check_bus(i[6]);
        sz_a = i[3:2]; lo_a = e_addr[1:0]; err_a = e_err;
        req_valid = 1'b0;
        seed = nxt(seed); rd = seed; mem_rdata = rd;
        @(negedge clk);
        chk(out_valid === 1'b0, "R11 idle after request", {31'd0, out_valid}, 32'd0);
        if (!i[6]) begin
          chk(ld_valid === !err_a, "R10 R11 load valid", {31'd0, ld_valid}, {31'd0, !err_a});
          exp_ld = ld_model(sz_a, lo_a, rd);
          if (!err_a) chk(ld_data === exp_ld, "R9 load extraction", ld_data, exp_ld);
        end else chk(ld_valid === 1'b0, "R11 no load result for store", {31'd0, ld_valid}, 32'd0);
      end

      // back-to-back: load A result overlaps request B
      for (int k = 0; k < 8; k++) begin
        seed = nxt(seed);
        drive(1'b0, k[1] ? 2'd1 : 2'd0, 2'd1, {seed[31:3], k[2], k[0], 1'b0}, 32'd0, 32'd0, 1'b0, 5'd0, 1'b0, 32'd0);
        @(negedge clk);
        check_bus(1'b0);
        sz_a = req_size; lo_a = e_addr[1:0];
        seed = nxt(seed); rd = seed; mem_rdata = rd;
        exp_ld = ld_model(sz_a, lo_a, rd);
        seed = nxt(seed);
        drive(1'b1, 2'd0, 2'd2, seed, 32'd4, 32'd3, 1'b1, 5'd2, 1'b1, ~seed);
        @(negedge clk);
        chk(ld_valid === 1'b1 && ld_data === exp_ld, "R9 R11 overlapped load", ld_data, exp_ld);
        check_bus(1'b1);
        req_valid = 1'b0;
        @(negedge clk);
      end

      // R5: pin was flipped after reset; byte store at offset 0 must follow latched order
      drive(1'b1, 2'd0, 2'd0, 32'h100, 32'd0, 32'd0, 1'b0, 5'd0, 1'b0, 32'hA5);
      @(negedge clk);
      chk(out_be === (bg[0] ? 4'b1000 : 4'b0001), "R5 order held after reset",
          {28'd0, out_be}, bg[0] ? 32'h8 : 32'h1);
      req_valid = 1'b0;
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule